// File: doc/BRIEF.md
# Leaf Reset Consistency Checker

This block watches one leaf reset and confirms that each time it asserts, the assertion has a cause: either the parent reset it derives from also asserted, or a local software reset request was active. Both reset lines may live in clock domains unrelated to the checker. Each one therefore sets a sticky flag asynchronously when it goes low, and that flag then passes through a synchronizer into the checker's clock.

The two indications can arrive in either order, because each one crosses its own synchronizer. When one is seen without the other, the checker waits for the missing one within a bounded window. If the window expires, it raises an error that stays set until the checker's own reset. Once a valid pairing is seen, the checker clears the flags and waits until both resets are released before it re-arms. For a leaf that has no software reset, the request input is tied low.

Top module: `leaf_rst_check`

## Requirements
- R1: After the local reset `rst_ni` is released, `err_o` is low.
- R2: A leaf assertion and a parent assertion made together give no error.
- R3: A parent assertion that follows a leaf assertion within the timeout window (3 cycles later) is accepted without error; a parent assertion 20 cycles late gives an error.
- R4: A leaf assertion that follows a parent assertion within the window (3 cycles later) is accepted; a leaf assertion 20 cycles late gives an error.
- R5: An unjustified leaf assertion leaves `err_o` low for at least TIMEOUT cycles. `err_o` goes high within TIMEOUT+SYNC_STAGES+4 cycles.
- R6: A parent assertion with no leaf assertion gives an error.
- R7: A leaf assertion while `sw_req_i` is high is justified, with no parent assertion and no error.
- R8: `sw_req_i` does not stand in for a missing leaf: a parent assertion alone gives an error even while `sw_req_i` is high.
- R9: Once a pairing is accepted, holding the resets asserted for longer than the window gives no error.
- R10: After both resets are released, the checker re-arms, so a later unjustified leaf assertion is flagged.
- R11: `err_o` stays high after the resets are released and is cleared only by `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Checker clock |
| rst_ni | input | 1 | Checker asynchronous reset, active low |
| parent_rst_ni | input | 1 | Parent reset, active low, asynchronous to clk_i |
| leaf_rst_ni | input | 1 | Leaf reset under check, active low, asynchronous to clk_i |
| sw_req_i | input | 1 | Software reset request for the leaf, synchronous to clk_i; tie low if none |
| err_o | output | 1 | Sticky consistency error |

## Verification
A reset edge reaches the state machine three clock edges after it occurs: one edge to set the flag and clock the first synchronizer stage, a second edge for the second stage, and a third edge for the state register. With the default TIMEOUT of 8, an unpaired leaf therefore raises `err_o` on the twelfth edge. Inputs change on falling edges and outputs are sampled on falling edges. The timing check samples after 9 edges, where low is expected, and after 14 edges, where high is expected. Every other check is placed at least 30 cycles after the last stimulus, so these checks do not depend on exact latency.

// File: rtl/leaf_chk_pkg.sv
package leaf_chk_pkg;
  typedef enum logic [2:0] {
    CHK_IDLE,
    CHK_WAIT_PAR,
    CHK_WAIT_LEAF,
    CHK_WAIT_REL,
    CHK_ERR
  } chk_state_e;
endpackage

// File: rtl/leaf_flag.sv
module leaf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_ni,
  input  logic clr_i,
  output logic q_o
);
  // async set while the watched reset is low; clear only once it has lifted
  always_ff @(posedge clk_i or negedge rst_ni or negedge set_ni) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (!set_ni) q_o <= 1'b1;
    else if (clr_i)   q_o <= 1'b0;
  end

  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_ni |=> q_o);
endmodule

// File: rtl/leaf_sync.sv
module leaf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/leaf_chk_fsm.sv
module leaf_chk_fsm
  import leaf_chk_pkg::*;
#(
  parameter int TIMEOUT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic leaf_seen_i,
  input  logic par_seen_i,
  input  logic sw_req_i,
  output logic clr_o,
  output logic err_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  chk_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    clr_o = 1'b0;
    unique case (st_q)
      CHK_IDLE: begin
        if (leaf_seen_i && (par_seen_i || sw_req_i)) begin
          st_d = CHK_WAIT_REL;
        end else if (leaf_seen_i) begin
          st_d  = CHK_WAIT_PAR;
          cnt_d = CW'(TIMEOUT);
        end else if (par_seen_i) begin
          st_d  = CHK_WAIT_LEAF;
          cnt_d = CW'(TIMEOUT);
        end
      end
      CHK_WAIT_PAR: begin
        if (par_seen_i || sw_req_i) st_d = CHK_WAIT_REL;
        else if (cnt_q == '0)       st_d = CHK_ERR;
        else                        cnt_d = cnt_q - CW'(1);
      end
      CHK_WAIT_LEAF: begin
        if (leaf_seen_i)      st_d = CHK_WAIT_REL;
        else if (cnt_q == '0) st_d = CHK_ERR;
        else                  cnt_d = cnt_q - CW'(1);
      end
      CHK_WAIT_REL: begin
        // flags cannot clear while their reset is still held low
        clr_o = 1'b1;
        if (!leaf_seen_i && !par_seen_i) st_d = CHK_IDLE;
      end
      CHK_ERR: st_d = CHK_ERR;
      default: st_d = CHK_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CHK_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign err_o = (st_q == CHK_ERR);

  assert_err_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_err_after_window_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(cnt_q) == '0));
  assert_no_err_when_paired_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CHK_WAIT_REL) |=> !err_o);
  assert_err_from_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> ($past(st_q) == CHK_WAIT_PAR || $past(st_q) == CHK_WAIT_LEAF));
endmodule

// File: rtl/leaf_rst_check.sv
module leaf_rst_check #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic parent_rst_ni,
  input  logic leaf_rst_ni,
  input  logic sw_req_i,
  output logic err_o
);
  localparam int NIND = 2;  // index 0: leaf, 1: parent

  logic [NIND-1:0] set_n, flag, seen;
  logic            clr;

  assign set_n = {parent_rst_ni, leaf_rst_ni};

  for (genvar g = 0; g < NIND; g++) begin : g_ind
    leaf_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_ni (set_n[g]),
      .clr_i  (clr),
      .q_o    (flag[g])
    );
    leaf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (flag[g]),
      .q_o    (seen[g])
    );
  end

  leaf_chk_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .leaf_seen_i (seen[0]),
    .par_seen_i  (seen[1]),
    .sw_req_i    (sw_req_i),
    .clr_o       (clr),
    .err_o       (err_o)
  );
endmodule

// File: tb/sim_leaf_rst_check.sv
module sim_leaf_rst_check;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {parent_first, gap[4:0], second_present, sw, exp_err}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 5'd0,  1'b1, 1'b0, 1'b0},  // R2 together
    {1'b0, 5'd3,  1'b1, 1'b0, 1'b0},  // R3 parent late, in window
    {1'b1, 5'd3,  1'b1, 1'b0, 1'b0},  // R4 leaf late, in window
    {1'b0, 5'd0,  1'b0, 1'b0, 1'b1},  // R5 leaf only
    {1'b1, 5'd0,  1'b0, 1'b0, 1'b1},  // R6 parent only
    {1'b0, 5'd0,  1'b0, 1'b1, 1'b0},  // R7 leaf with sw request
    {1'b1, 5'd0,  1'b0, 1'b1, 1'b1},  // R8 parent only with sw request
    {1'b0, 5'd20, 1'b1, 1'b0, 1'b1},  // R3 parent too late
    {1'b1, 5'd20, 1'b1, 1'b0, 1'b1}   // R4 leaf too late
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic parent_rst_ni = 1'b1;
  logic leaf_rst_ni = 1'b1;
  logic sw_req_i = 1'b0;
  logic err_o;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  leaf_rst_check u0 (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .parent_rst_ni (parent_rst_ni),
    .leaf_rst_ni   (leaf_rst_ni),
    .sw_req_i      (sw_req_i),
    .err_o         (err_o)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic exp, input string tag, input string what);
    checks++;
    if (err_o !== exp) begin
      failures++;
      $display("FAIL %s %s: err_o actual=%b expected=%b", tag, what, err_o, exp);
    end
  endtask

  task automatic local_reset();
    rst_ni = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(3);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2";
      1, 7: return "R3";
      2, 8: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(2);
    check(1'b0, "R1", "after reset");

    for (int i = 0; i < NVEC; i++) begin
      local_reset();
      sw_req_i = VEC[i][1];
      if (VEC[i][8]) parent_rst_ni = 1'b0;
      else           leaf_rst_ni = 1'b0;
      cyc(int'(VEC[i][7:3]));
      if (VEC[i][2]) begin
        if (VEC[i][8]) leaf_rst_ni = 1'b0;
        else           parent_rst_ni = 1'b0;
      end
      cyc(30);  // long hold also covers R9 for paired cases
      check(VEC[i][0], vec_tag(i), "during hold");
      parent_rst_ni = 1'b1;
      leaf_rst_ni = 1'b1;
      cyc(10);
      sw_req_i = 1'b0;
      check(VEC[i][0], VEC[i][0] ? "R11" : "R9", "after release");
    end

    // R5: window bounds on an unpaired leaf
    local_reset();
    leaf_rst_ni = 1'b0;
    cyc(9);
    check(1'b0, "R5", "before window end");
    cyc(5);
    check(1'b1, "R5", "after window end");
    leaf_rst_ni = 1'b1;

    // R11: local reset clears the error
    local_reset();
    check(1'b0, "R11", "cleared by rst_ni");

    // R10: re-arm after a completed cycle
    parent_rst_ni = 1'b0;
    leaf_rst_ni = 1'b0;
    cyc(5);
    parent_rst_ni = 1'b1;
    leaf_rst_ni = 1'b1;
    cyc(10);
    check(1'b0, "R10", "after paired cycle");
    leaf_rst_ni = 1'b0;
    cyc(25);
    check(1'b1, "R10", "second leaf unjustified");
    leaf_rst_ni = 1'b1;
    cyc(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule